// File: doc/BRIEF.md
# Register-Mapped Pin Controller with Interrupt Capture

This block controls a bank of up to 32 general-purpose pins from a plain 32-bit register bus. Software selects which pins drive and which sense, and sets the driven level and the drive enable of each pin. A hand-off register gives any pin to an alternate function. Software can also read the current pad levels.

Every pin has its own event detector. The detector can be set to match a level of either polarity, one edge, or both edges. Each detected event sets a status bit whether or not the pin is masked. The single interrupt line is high while any status bit is set on an unmasked pin. Masking is changed through two write-one strobe registers, one that sets and one that clears mask bits, and the resulting mask can be read back. No acknowledge register exists: reading the status word clears it.

The bus is a single-cycle strobe interface. Read data is combinational from the addressed register, and a read or write takes effect at the clock edge that ends the strobe cycle. The reset input is asynchronous and active low. Inside the block its release is synchronised through two flops.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, the hand-off word (0x00), the direction word (0x04) and the mask word (0x14) read all ones for the implemented pins. Every other readable word reads 0, pin_oe and pin_out are 0, alt_sel is all ones and irq is 0.
- R2: The words at 0x00, 0x04, 0x08, 0x0C, 0x24, 0x28 and 0x2C read back what was last written. The words at 0x18 and 0x1C read 0, and writes to the pad-level word at 0x10 are ignored.
- R3: A pin drives only when its direction bit is 0 (0 = output, 1 = input), its hand-off bit is 0 and its 0x08 bit is 1. In that case pin_oe is 1 and pin_out equals its 0x0C bit; otherwise both are 0. alt_sel mirrors the hand-off word.
- R4: The word at 0x10 shows each pad level two clock edges after the pad changes, through a two-flop synchroniser, for every pin whatever its direction.
- R5: Writing 1s to 0x18 clears those mask bits, and writing 1s to 0x1C sets them. Zero bits leave the mask unchanged, and the mask at 0x14 reads 1 for a masked pin.
- R6: With the kind bit (0x24) at 0 and the both-edges bit (0x2C) at 0, a rising edge sets the status bit when the polarity bit (0x28) is 1, and a falling edge sets it when the polarity bit is 0.
- R7: With the kind bit at 0 and the both-edges bit at 1, rising and falling edges both set the status bit.
- R8: With the kind bit at 1, the status bit sets while the synchronised pad equals the polarity bit (1 = high, 0 = low). A level that still holds reads as set again after a clearing read.
- R9: Status bits set regardless of the mask. irq is the OR of status bits whose mask bit is 0.
- R10: Reading the status word at 0x20 returns it and clears every bit at that edge. An event detected on the same edge as the clearing read stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while the read strobe is high |
| pin_in | input | NPINS | Pad input levels, asynchronous |
| pin_out | output | NPINS | Pad output levels |
| pin_oe | output | NPINS | Pad drive enables |
| alt_sel | output | NPINS | Pins handed to the alternate function |
| irq | output | 1 | Combined interrupt request |

## Verification
A clearing read of the status word and a newly detected edge can fall on the same clock edge. If the clear won, the event would be lost with no trace. The bench raises a pad exactly two edges before a status read commits, so the detector fires on the commit edge. It then checks that the read itself returns the word without that bit, and that the next read returns the bit set. The same read path is also checked against a level condition that is still active, which must reappear right after every clear.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int unsigned BUS_W = 32;

  // Word index = byte address / 4
  typedef enum logic [3:0] {
    RG_HANDOFF = 4'd0,
    RG_DIR     = 4'd1,
    RG_DRVEN   = 4'd2,
    RG_DOUT    = 4'd3,
    RG_PADLVL  = 4'd4,
    RG_MASK    = 4'd5,
    RG_UNMASK  = 4'd6,
    RG_SETMASK = 4'd7,
    RG_STATUS  = 4'd8,
    RG_KIND    = 4'd9,
    RG_POL     = 4'd10,
    RG_BOTH    = 4'd11
  } reg_sel_e;

  localparam int unsigned NUM_WORDS = 12;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_i,
  output logic [NPINS-1:0] sync_o
);

  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] stab_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        stab_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= pad_i[g];
        stab_q[g] <= meta_q[g];
      end
    end
  end

  assign sync_o = stab_q;

endmodule

// File: rtl/pinbank_event.sv
module pinbank_event #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl_i,    // synchronised pad levels
  input  logic [NPINS-1:0] kind_i,   // 1 = level, 0 = edge
  input  logic [NPINS-1:0] pol_i,    // high/rising = 1
  input  logic [NPINS-1:0] both_i,   // edge mode: both edges
  input  logic             clr_i,    // status read this cycle
  output logic [NPINS-1:0] status_o
);

  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] status_q;
  logic [NPINS-1:0] status_d;
  logic [NPINS-1:0] hit;

  for (genvar g = 0; g < NPINS; g++) begin : g_det
    logic rise;
    logic fall;
    logic lvl_match;
    assign rise      = lvl_i[g] & ~prev_q[g];
    assign fall      = ~lvl_i[g] & prev_q[g];
    assign lvl_match = (lvl_i[g] == pol_i[g]);

    always_comb begin
      if (kind_i[g])      hit[g] = lvl_match;
      else if (both_i[g]) hit[g] = rise | fall;
      else if (pol_i[g])  hit[g] = rise;
      else                hit[g] = fall;
    end
  end

  // Set has priority over the read clear
  always_comb begin
    status_d = clr_i ? '0 : status_q;
    status_d = status_d | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= lvl_i;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

  assert_set_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((status_q & $past(hit)) == $past(hit)));

  assert_clear_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((status_q & ~$past(hit)) == '0));

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] status_i,
  output logic [NPINS-1:0] handoff_o,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] drven_o,
  output logic [NPINS-1:0] dout_o,
  output logic [NPINS-1:0] mask_o,
  output logic [NPINS-1:0] kind_o,
  output logic [NPINS-1:0] pol_o,
  output logic [NPINS-1:0] both_o,
  output logic             stat_clr_o
);

  localparam int unsigned IW = AW - 2;

  logic [IW-1:0]    widx;
  logic             in_range;
  reg_sel_e         rsel;
  logic             wr_hit;
  logic             rd_hit;
  logic [NPINS-1:0] wbits;

  logic [NPINS-1:0] handoff_q, handoff_d;
  logic [NPINS-1:0] dir_q, dir_d;
  logic [NPINS-1:0] drven_q, drven_d;
  logic [NPINS-1:0] dout_q, dout_d;
  logic [NPINS-1:0] mask_q, mask_d;
  logic [NPINS-1:0] kind_q, kind_d;
  logic [NPINS-1:0] pol_q, pol_d;
  logic [NPINS-1:0] both_q, both_d;

  function automatic logic [BUS_W-1:0] widen(input logic [NPINS-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  assign widx     = bus_addr[AW-1:2];
  assign in_range = (widx < IW'(NUM_WORDS));
  assign rsel     = reg_sel_e'(widx[3:0]);
  assign wr_hit   = bus_sel & bus_wr & in_range;
  assign rd_hit   = bus_sel & ~bus_wr & in_range;
  assign wbits    = bus_wdata[NPINS-1:0];

  // Next state
  always_comb begin
    handoff_d = handoff_q;
    dir_d     = dir_q;
    drven_d   = drven_q;
    dout_d    = dout_q;
    mask_d    = mask_q;
    kind_d    = kind_q;
    pol_d     = pol_q;
    both_d    = both_q;
    if (wr_hit) begin
      case (rsel)
        RG_HANDOFF: handoff_d = wbits;
        RG_DIR:     dir_d     = wbits;
        RG_DRVEN:   drven_d   = wbits;
        RG_DOUT:    dout_d    = wbits;
        RG_UNMASK:  mask_d    = mask_q & ~wbits;
        RG_SETMASK: mask_d    = mask_q | wbits;
        RG_KIND:    kind_d    = wbits;
        RG_POL:     pol_d     = wbits;
        RG_BOTH:    both_d    = wbits;
        default:    ;
      endcase
    end
  end

  // Registers, written only on a bus write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      handoff_q <= '1;
      dir_q     <= '1;
      drven_q   <= '0;
      dout_q    <= '0;
      mask_q    <= '1;
      kind_q    <= '0;
      pol_q     <= '0;
      both_q    <= '0;
    end else if (wr_hit) begin
      handoff_q <= handoff_d;
      dir_q     <= dir_d;
      drven_q   <= drven_d;
      dout_q    <= dout_d;
      mask_q    <= mask_d;
      kind_q    <= kind_d;
      pol_q     <= pol_d;
      both_q    <= both_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      case (rsel)
        RG_HANDOFF: bus_rdata = widen(handoff_q);
        RG_DIR:     bus_rdata = widen(dir_q);
        RG_DRVEN:   bus_rdata = widen(drven_q);
        RG_DOUT:    bus_rdata = widen(dout_q);
        RG_PADLVL:  bus_rdata = widen(lvl_i);
        RG_MASK:    bus_rdata = widen(mask_q);
        RG_STATUS:  bus_rdata = widen(status_i);
        RG_KIND:    bus_rdata = widen(kind_q);
        RG_POL:     bus_rdata = widen(pol_q);
        RG_BOTH:    bus_rdata = widen(both_q);
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign stat_clr_o = rd_hit && (rsel == RG_STATUS);

  assign handoff_o = handoff_q;
  assign dir_o     = dir_q;
  assign drven_o   = drven_q;
  assign dout_o    = dout_q;
  assign mask_o    = mask_q;
  assign kind_o    = kind_q;
  assign pol_o     = pol_q;
  assign both_o    = both_q;

  assert_unmask_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && rsel == RG_UNMASK) |=> ((mask_q & $past(wbits)) == '0));

  assert_setmask_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && rsel == RG_SETMASK) |=> ((mask_q & $past(wbits)) == $past(wbits)));

  assert_keep_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (rsel == RG_UNMASK || rsel == RG_SETMASK))
      |=> ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits))));

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] alt_sel,
  output logic             irq
);

  initial begin
    assert_width_cfg : assert (NPINS >= 1 && NPINS <= BUS_W && AW >= 6);
  end

  // Reset release synchroniser
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NPINS-1:0] lvl;
  logic [NPINS-1:0] status;
  logic [NPINS-1:0] handoff, dir, drven, dout, mask, kind, pol, both;
  logic             stat_clr;
  logic [NPINS-1:0] drive;

  pinbank_sync #(.NPINS(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pad_i  (pin_in),
    .sync_o (lvl)
  );

  pinbank_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .lvl_i      (lvl),
    .status_i   (status),
    .handoff_o  (handoff),
    .dir_o      (dir),
    .drven_o    (drven),
    .dout_o     (dout),
    .mask_o     (mask),
    .kind_o     (kind),
    .pol_o      (pol),
    .both_o     (both),
    .stat_clr_o (stat_clr)
  );

  pinbank_event #(.NPINS(NPINS)) u_event (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .lvl_i    (lvl),
    .kind_i   (kind),
    .pol_i    (pol),
    .both_i   (both),
    .clr_i    (stat_clr),
    .status_o (status)
  );

  // Pad side: drive only outputs not handed off
  assign drive   = ~handoff & ~dir & drven;
  assign pin_oe  = drive;
  assign pin_out = dout & drive;
  assign alt_sel = handoff;
  assign irq     = |(status & ~mask);

  assert_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask == '1) |-> !irq);

endmodule

// File: tb/pinbank_ctrl_test.sv
module pinbank_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic [NP-1:0] alt_sel;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinbank_ctrl #(.NPINS(NP), .AW(6)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_sel(alt_sel), .irq(irq)
  );

  // {is_write, byte address, write data or expected read data}
  localparam int NV = 15;
  localparam logic [38:0] TBL [NV] = '{
    {1'b0, 6'h00, 32'hFFFF_FFFF},  // R1 hand-off reset
    {1'b0, 6'h04, 32'hFFFF_FFFF},  // R1 direction reset
    {1'b0, 6'h14, 32'hFFFF_FFFF},  // R1 mask reset
    {1'b0, 6'h08, 32'h0000_0000},  // R1 drive-enable reset
    {1'b1, 6'h00, 32'h0000_0000},
    {1'b1, 6'h04, 32'hFFFF_0000},
    {1'b1, 6'h08, 32'h0000_FF0F},
    {1'b1, 6'h0C, 32'h1234_5678},
    {1'b0, 6'h0C, 32'h1234_5678},  // R2 readback
    {1'b1, 6'h18, 32'h0000_0003},
    {1'b0, 6'h14, 32'hFFFF_FFFC},  // R5 unmask
    {1'b1, 6'h1C, 32'h0000_0001},
    {1'b0, 6'h14, 32'hFFFF_FFFD},  // R5 remask, zeros keep
    {1'b0, 6'h18, 32'h0000_0000},  // R2 strobe word reads 0
    {1'b0, 6'h04, 32'hFFFF_0000}   // R2 readback
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    wait_edges(4);

    // R1 pad-side reset state
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 alt_sel", alt_sel, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    bus_read(6'h20, rd); chk("R1 status", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][38]) bus_write(TBL[i][37:32], TBL[i][31:0]);
      else begin
        bus_read(TBL[i][37:32], rd);
        chk("R1/R2/R5 table", rd, TBL[i][31:0]);
      end
    end

    // R3 drive gating
    chk("R3 pin_oe", pin_oe, 32'h0000_FF0F);
    chk("R3 pin_out", pin_out, 32'h0000_5608);
    chk("R3 alt_sel", alt_sel, 32'h0);
    bus_write(6'h00, 32'h0000_000F);
    chk("R3 handoff oe", pin_oe, 32'h0000_FF00);
    chk("R3 handoff out", pin_out, 32'h0000_5600);
    chk("R3 handoff alt", alt_sel, 32'h0000_000F);
    bus_write(6'h00, 32'h0);

    // R2 pad word ignores writes
    bus_write(6'h10, 32'hDEAD_BEEF);
    bus_read(6'h10, rd); chk("R2 pad word write ignored", rd, 32'h0);

    // R4 two-edge synchroniser latency
    @(negedge clk) pin_in = 32'hA5A5_0000;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'h10;
    @(negedge clk); #1 chk("R4 after one edge", bus_rdata, 32'h0);
    @(negedge clk); #1 chk("R4 after two edges", bus_rdata, 32'hA5A5_0000);
    @(negedge clk) bus_sel = 1'b0;

    // Interrupt setup: all inputs, pin1/pin6 rising, pin4 both edges
    bus_write(6'h04, 32'hFFFF_FFFF);
    bus_write(6'h28, 32'h0000_0042);
    bus_write(6'h2C, 32'h0000_0010);
    bus_write(6'h18, 32'h0000_0040);
    bus_read(6'h20, rd);
    bus_read(6'h20, rd); chk("R6 no event", rd, 32'h0);

    // R6 rising edge on enabled pin1, R9 irq
    @(negedge clk) pin_in[1] = 1'b1;
    wait_edges(3);
    chk("R9 irq unmasked event", {31'b0, irq}, 32'h1);
    bus_read(6'h20, rd); chk("R6 rising edge", rd, 32'h0000_0002);
    chk("R10 irq after clear", {31'b0, irq}, 32'h0);
    bus_read(6'h20, rd); chk("R10 cleared", rd, 32'h0);

    // R6 falling edge with polarity 0 on pin2
    @(negedge clk) pin_in[2] = 1'b1;
    wait_edges(3);
    bus_read(6'h20, rd); chk("R6 rise ignored when falling", rd, 32'h0);
    @(negedge clk) pin_in[2] = 1'b0;
    wait_edges(3);
    bus_read(6'h20, rd); chk("R6 falling edge", rd, 32'h0000_0004);

    // R7 both edges on masked pin4, R9 masked keeps irq low
    @(negedge clk) pin_in[4] = 1'b1;
    wait_edges(3);
    chk("R9 masked irq low", {31'b0, irq}, 32'h0);
    bus_read(6'h20, rd); chk("R7 rise", rd, 32'h0000_0010);
    @(negedge clk) pin_in[4] = 1'b0;
    wait_edges(3);
    bus_read(6'h20, rd); chk("R7 fall", rd, 32'h0000_0010);

    // R8 level low on pin5 (pin low)
    bus_write(6'h24, 32'h0000_0020);
    bus_write(6'h18, 32'h0000_0020);
    wait_edges(1);
    chk("R9 level irq", {31'b0, irq}, 32'h1);
    bus_read(6'h20, rd); chk("R8 level low", rd, 32'h0000_0020);
    bus_read(6'h20, rd); chk("R8 level persists", rd, 32'h0000_0020);
    @(negedge clk) pin_in[5] = 1'b1;
    wait_edges(3);
    bus_read(6'h20, rd);
    bus_read(6'h20, rd); chk("R8 level gone", rd, 32'h0);
    chk("R8 irq gone", {31'b0, irq}, 32'h0);

    // R8 level high on pin5
    bus_write(6'h28, 32'h0000_0062);
    bus_read(6'h20, rd); chk("R8 level high", rd, 32'h0000_0020);

    // R10 collision: pin6 edge detected on the clearing read edge
    @(negedge clk) pin_in[6] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'h20;
    #1 chk("R10 read before event", bus_rdata, 32'h0000_0020);
    @(negedge clk) bus_sel = 1'b0;
    bus_read(6'h20, rd); chk("R10 event kept over clear", rd, 32'h0000_0060);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule